// File: doc/BRIEF.md
# Masked Step Sequencer

This block plays back a short, stored list of output patterns onto a 16-bit output word, one pattern per step. A mask register decides which output bits belong to the sequencer. Where a mask bit is 1, the output bit comes from the current step's pattern. Where it is 0, the output bit is passed through unchanged from a separate free input, so other logic can own those bits.

Position 0 is a home step. Steps 1 up to a programmable last step form the repeating cycle. In event mode, a rising edge on the advance input moves the sequencer one step. In timed mode, the sequencer steps by itself after a per-step dwell, which is counted in tick pulses. After the last step, the next step goes back to step 1.

A small configuration port loads the pattern table, the dwell table, the mask and the last-step register. The port is only honoured while the sequencer is not running.

Top module: `step_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the position to 0, clears done, clears the held step pattern and the mask (all bits free) and sets the last step to DEPTH-1.
- R2: Each bit of dout equals the held step pattern bit where the mask bit is 1, and the free_in bit where the mask bit is 0. A mask change or a free_in change shows on dout in the same cycle.
- R3: With time_mode low, the position advances at the first clock edge where advance is high after being low. Holding advance high gives exactly one step, and no step occurs without such a rising edge.
- R4: The first step from home (position 0) goes to position 1 and loads pattern entry 1.
- R5: done is high exactly while the position equals the last step after a step has landed there.
- R6: A step taken when the position is at or beyond the last step goes to position 1. Otherwise it goes to position+1. Each step loads the pattern entry of the new position.
- R7: Configuration writes (cfg_we high at a clock edge) select their target with cfg_sel: 0 is the pattern entry at cfg_addr, 1 is the dwell entry at cfg_addr (low TW bits of cfg_data), 2 is the mask, and 3 is the last step (low AW bits). A write while run_en is high has no effect.
- R8: Writing the last step returns the position to 0, clears done and the held pattern. A written value of 0 is stored as 1.
- R9: With time_mode and run_en high, the sequencer steps after the dwell entry of the current position has counted that many tick pulses (a dwell of 0 acts as 1). The count restarts after each step, and the advance input is ignored.
- R10: In timed mode the count moves only on cycles with tick high. With run_en low the count is cleared and no timed step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 pattern, 1 dwell, 2 mask, 3 last step |
| cfg_addr | input | AW | Table entry for pattern or dwell writes |
| cfg_data | input | WIDTH | Write data |
| run_en | input | 1 | Run enable; blocks writes, gates timed stepping |
| time_mode | input | 1 | 1 = timed stepping, 0 = event stepping |
| tick | input | 1 | Timebase pulse counted by the dwell timer |
| advance | input | 1 | Event step request, acted on at its rising edge |
| free_in | input | WIDTH | Values for output bits not owned by the sequencer |
| dout | output | WIDTH | Merged output word |
| position | output | AW | Current step, 0 = home |
| done | output | 1 | At the last step |

## Verification
The hardest situation to reach is the timed cycle crossing the wrap point. Reaching it requires distinct dwell values at every position and an exact count of elapsed ticks between position changes. The bench loads different dwell lengths into each entry and shortens the cycle through the last-step register. It then measures the cycle count of each interval through the home step, steps 1 to 3 and the wrap back to 1. Writes attempted while running are checked later: the sequencer is stepped onto the affected entry and the output word is compared.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        CFG_PATTERN = 2'd0,
        CFG_DWELL   = 2'd1,
        CFG_MASK    = 2'd2,
        CFG_LAST    = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/seq_edge_detect.sv
module seq_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = sig_in;
        rise     = sig_in & ~e_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end
endmodule

// File: rtl/seq_cfg_store.sv
module seq_cfg_store
    import seq_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int TW    = 12,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data,
    input  logic [AW-1:0]    pat_addr,
    input  logic [AW-1:0]    dwell_addr,
    output logic [WIDTH-1:0] pat_rd,
    output logic [TW-1:0]    dwell_rd,
    output logic [WIDTH-1:0] mask_q,
    output logic [AW-1:0]    last_q,
    output logic             last_wr
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] pat;
        logic [DEPTH-1:0][TW-1:0]    dwell;
        logic [WIDTH-1:0]            mask;
        logic [AW-1:0]               last;
    } store_t;

    store_t s_d, s_q;
    logic [AW-1:0] last_wval;

    always_comb begin
        s_d       = s_q;
        last_wr   = 1'b0;
        last_wval = (data[AW-1:0] == '0) ? AW'(1) : data[AW-1:0];
        if (we) begin
            case (cfg_sel_e'(sel))
                CFG_PATTERN: s_d.pat[addr]   = data;
                CFG_DWELL:   s_d.dwell[addr] = data[TW-1:0];
                CFG_MASK:    s_d.mask        = data;
                CFG_LAST: begin
                    s_d.last = last_wval;
                    last_wr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.last <= AW'(DEPTH - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign pat_rd   = s_q.pat[pat_addr];
    assign dwell_rd = s_q.dwell[dwell_addr];
    assign mask_q   = s_q.mask;
    assign last_q   = s_q.last;
endmodule

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] preset,
    output logic          expire
);
    typedef struct packed {
        logic [TW-1:0] count;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [TW:0] count_inc;
    logic [TW:0] preset_eff;

    always_comb begin
        t_d        = t_q;
        count_inc  = {1'b0, t_q.count} + 1'b1;
        preset_eff = (preset == '0) ? (TW+1)'(1) : {1'b0, preset};
        expire     = run & tick & (count_inc >= preset_eff);
        if (!run || expire) t_d.count = '0;
        else if (tick)      t_d.count = count_inc[TW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int TW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WIDTH-1:0] cfg_data,
    input  logic             run_en,
    input  logic             time_mode,
    input  logic             tick,
    input  logic             advance,
    input  logic [WIDTH-1:0] free_in,
    output logic [WIDTH-1:0] dout,
    output logic [AW-1:0]    position,
    output logic             done
);
    typedef struct packed {
        logic [AW-1:0]    pos;
        logic             done;
        logic [WIDTH-1:0] held;
    } seq_t;

    seq_t q_d, q_q;

    logic             adv_rise;
    logic             expire;
    logic             step;
    logic [AW-1:0]    next_pos;
    logic [WIDTH-1:0] pat_rd;
    logic [TW-1:0]    dwell_rd;
    logic [WIDTH-1:0] mask_q;
    logic [AW-1:0]    last_q;
    logic             last_wr;

    seq_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (advance),
        .rise   (adv_rise)
    );

    seq_cfg_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .TW    (TW),
        .AW    (AW)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we & ~run_en),
        .sel        (cfg_sel),
        .addr       (cfg_addr),
        .data       (cfg_data),
        .pat_addr   (next_pos),
        .dwell_addr (q_q.pos),
        .pat_rd     (pat_rd),
        .dwell_rd   (dwell_rd),
        .mask_q     (mask_q),
        .last_q     (last_q),
        .last_wr    (last_wr)
    );

    seq_dwell_timer #(
        .TW (TW)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run_en & time_mode),
        .tick   (tick),
        .preset (dwell_rd),
        .expire (expire)
    );

    always_comb begin
        q_d      = q_q;
        step     = time_mode ? expire : adv_rise;
        next_pos = (q_q.pos >= last_q) ? AW'(1) : q_q.pos + 1'b1;
        if (last_wr) begin
            q_d.pos  = '0;
            q_d.done = 1'b0;
            q_d.held = '0;
        end else if (step) begin
            q_d.pos  = next_pos;
            q_d.done = (next_pos == last_q);
            q_d.held = pat_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_merge
        assign dout[b] = mask_q[b] ? q_q.held[b] : free_in[b];
    end

    assign position = q_q.pos;
    assign done     = q_q.done;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          time_mode,
    input logic          advance,
    input logic          tick,
    input logic          cfg_we,
    input logic [AW-1:0] position,
    input logic [AW-1:0] last_step,
    input logic          done
);
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (position == '0 && !done));

    p_event_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!time_mode && !advance && !cfg_we) |=> $stable(position));

    p_done_last_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (position == last_step));

    p_step_legal_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(position) |-> (position == $past(position) + 1'b1
                                || position == AW'(1) || position == '0));

    p_pos_bound_r8: assert property (@(posedge clk) disable iff (rst)
        position <= last_step);

    p_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (time_mode && !tick && !cfg_we) |=> $stable(position));
endmodule

bind step_sequencer seq_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .time_mode (time_mode),
    .advance   (advance),
    .tick      (tick),
    .cfg_we    (cfg_we),
    .position  (position),
    .last_step (last_q),
    .done      (done)
);

// File: tb/tb_step_sequencer.sv
module tb_step_sequencer;
    localparam int WIDTH = 16;
    localparam int DEPTH = 8;
    localparam int TW    = 12;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [WIDTH-1:0] cfg_data = '0;
    logic             run_en = 1'b0;
    logic             time_mode = 1'b0;
    logic             tick = 1'b0;
    logic             advance = 1'b0;
    logic [WIDTH-1:0] free_in = 16'h5A40;
    logic [WIDTH-1:0] dout;
    logic [AW-1:0]    position;
    logic             done;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    step_sequencer #(.WIDTH(WIDTH), .DEPTH(DEPTH), .TW(TW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .run_en(run_en),
        .time_mode(time_mode), .tick(tick), .advance(advance),
        .free_in(free_in), .dout(dout), .position(position), .done(done)
    );

    // {position, done, dout} after each advance edge; mask 001F, free_in 5A40
    localparam logic [20:0] VECS [0:5] = '{
        {4'd1, 1'b0, 16'h5A41},   // R4 home -> 1
        {4'd2, 1'b0, 16'h5A4A},
        {4'd3, 1'b0, 16'h5A54},
        {4'd4, 1'b1, 16'h5A43},   // R5 done at last step
        {4'd1, 1'b0, 16'h5A41},   // R6 wrap to 1
        {4'd2, 1'b0, 16'h5A4A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] addr,
                             input logic [WIDTH-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_adv();
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic measure(output int n);
        logic [AW-1:0] old;
        old = position;
        n = 0;
        while (position == old && n < 64) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state: mask clear so dout follows free_in
        check("R1 pos", 32'(position), 0);
        check("R1 done", 32'(done), 0);
        check("R1 dout", 32'(dout), 32'h5A40);

        // R7 load tables and mask
        cfg_write(2'd0, 3'd0, 16'h0000);
        cfg_write(2'd0, 3'd1, 16'hFF21);
        cfg_write(2'd0, 3'd2, 16'h0C0A);
        cfg_write(2'd0, 3'd3, 16'h0014);
        cfg_write(2'd0, 3'd4, 16'hA5E3);
        cfg_write(2'd3, 3'd0, 16'h0004);
        cfg_write(2'd2, 3'd0, 16'h001F);
        check("R2 mask home", 32'(dout), 32'h5A40);

        for (int i = 0; i < 6; i++) begin
            pulse_adv();
            check("R3 R6 pos", 32'(position), 32'(VECS[i][20:17]));
            check("R5 done", 32'(done), 32'(VECS[i][16]));
            check("R2 dout", 32'(dout), 32'(VECS[i][15:0]));
        end

        // R7 writes ignored while run_en high (at pos 2)
        @(negedge clk);
        run_en = 1'b1;
        cfg_write(2'd0, 3'd3, 16'h001F);
        cfg_write(2'd2, 3'd0, 16'hFFFF);
        @(negedge clk);
        run_en = 1'b0;
        check("R7 mask kept", 32'(dout), 32'h5A4A);
        pulse_adv();
        check("R7 pattern kept", 32'(dout), 32'h5A54);

        // R2 free bits follow free_in
        free_in = 16'hFFFF;
        #1ns;
        check("R2 free bits", 32'(dout), 32'hFFF4);
        free_in = 16'h5A40;

        // R3 held advance steps once
        @(negedge clk);
        advance = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 held pos", 32'(position), 4);
        check("R5 held done", 32'(done), 1);
        advance = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 no edge", 32'(position), 4);

        // R8 length write returns home; value 0 stored as 1
        cfg_write(2'd3, 3'd0, 16'h0000);
        check("R8 home pos", 32'(position), 0);
        check("R8 done clr", 32'(done), 0);
        check("R8 held clr", 32'(dout), 32'h5A40);
        pulse_adv();
        check("R8 len1 pos", 32'(position), 1);
        check("R8 len1 done", 32'(done), 1);
        pulse_adv();
        check("R6 len1 wrap", 32'(position), 1);
        check("R6 len1 done", 32'(done), 1);
        check("R6 len1 dout", 32'(dout), 32'h5A41);

        // R9 timed stepping with per-step dwell
        cfg_write(2'd1, 3'd0, 16'd2);
        cfg_write(2'd1, 3'd1, 16'd3);
        cfg_write(2'd1, 3'd2, 16'd1);
        cfg_write(2'd1, 3'd3, 16'd4);
        cfg_write(2'd3, 3'd0, 16'd3);
        @(negedge clk);
        time_mode = 1'b1; run_en = 1'b1; tick = 1'b1;
        measure(n); check("R9 dwell home", 32'(n), 2);
        check("R9 pos1", 32'(position), 1);
        measure(n); check("R9 dwell 1", 32'(n), 3);
        measure(n); check("R9 dwell 2", 32'(n), 1);
        check("R9 done 3", 32'(done), 1);
        measure(n); check("R9 dwell 3", 32'(n), 4);
        check("R9 wrap pos", 32'(position), 1);
        check("R9 wrap dout", 32'(dout), 32'h5A41);

        // R10 no tick: hold; R9 advance ignored
        tick = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 tick hold", 32'(position), 1);
        pulse_adv();
        check("R9 advance ignored", 32'(position), 1);
        run_en = 1'b0; tick = 1'b1;
        repeat (10) @(negedge clk);
        check("R10 run hold", 32'(position), 1);

        // R1 reset from mid-sequence
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        time_mode = 1'b0;
        @(negedge clk);
        check("R1 pos again", 32'(position), 0);
        check("R1 done again", 32'(done), 0);
        check("R1 mask cleared", 32'(dout), 32'h5A40);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule